// File: doc/BRIEF.md
# Cascadable ALU Slice

An 8-bit combinational arithmetic and logic slice meant to be tiled side by side into a wider datapath. Each slice takes two operands, a carry-in, a function code, an operand-B invert control and a shift code. It returns the result, a carry-out and a single shift-out bit, plus sign, zero and overflow flags. Wider words are built by feeding each slice's carry-out into the carry-in of the slice above it. Shifts chain the same way: a slice's shift-out is routed to the shift-in of the neighbour that receives the bit.

Eight functions are selected by a 3-bit code: add, subtract, AND, OR, XOR, NAND, NOR and XNOR. Operand B can be complemented ahead of any of them. The result of that function can then be moved one place left or right in the same pass, with the bit that enters supplied by a neighbour. Subtraction is formed as A plus the complemented B plus the carry-in, so the least significant slice is given a carry-in of 1 for a true difference. The adder inside is a ripple of eight 1-bit cells.

Top module: `alu_slice`

## Requirements
- R1: With func_i = 0 (add), the unshifted result is the low 8 bits of A + B' + cin_i and cout_o is bit 8 of that sum, where B' is B when binv_i = 0 and ~B when binv_i = 1.
- R2: With func_i = 1 (subtract), B is complemented once more after the binv_i stage, so the sum is A + ~B' + cin_i. With binv_i = 0 and cin_i = 1 this gives A - B.
- R3: func_i = 2, 3, 4, 5, 6 and 7 give the bitwise A&B', A|B', A^B', ~(A&B'), ~(A|B') and ~(A^B').
- R4: binv_i complements B before every one of the eight functions, giving forms such as A AND NOT B.
- R5: For the six logic functions (func_i 2 to 7), cout_o and ovf_o are 0.
- R6: For add and subtract, ovf_o is the XOR of the carry into bit 7 and the carry out of bit 7. It is taken on the unshifted sum.
- R7: With shift_i = 2'b01 (left), the output is the function result moved up one bit. Bit 0 takes sin_r_i, and sout_o is the function result's bit 7.
- R8: With shift_i = 2'b10 (right), the output is the function result moved down one bit. Bit 7 takes sin_l_i, and sout_o is the function result's bit 0.
- R9: With shift_i = 2'b00 or 2'b11, the function result passes unshifted and sout_o is 0.
- R10: sign_o equals bit 7 of res_o and zero_o is 1 exactly when res_o is all zeros, both taken after the shift.
- R11: Two slices chained carry-out to carry-in form a correct 16-bit add. With the low slice's shift-out fed to the high slice's sin_r_i, they form a correct 16-bit left shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| cin_i | input | 1 | Carry into bit 0 |
| func_i | input | 3 | Function code |
| binv_i | input | 1 | Complement B before the function |
| shift_i | input | 2 | 00 none, 01 left, 10 right, 11 none |
| sin_l_i | input | 1 | Bit entering bit 7 on a right shift |
| sin_r_i | input | 1 | Bit entering bit 0 on a left shift |
| res_o | output | 8 | Final result |
| cout_o | output | 1 | Carry out of bit 7 (arithmetic only) |
| sout_o | output | 1 | Bit leaving the slice on a shift |
| sign_o | output | 1 | Bit 7 of the final result |
| zero_o | output | 1 | Final result is zero |
| ovf_o | output | 1 | Signed overflow (arithmetic only) |

## Verification
Sums are tried near the sign and carry boundaries: 7F+01, FF+01, 80+80, and differences that borrow and that overflow. These separate carry-out from overflow and show whether overflow uses the carry into bit 7. The logic functions use A = CC and B = AA, which give all four bit pairings, so each encoding yields a distinct byte. Each is repeated with B complemented to show that the invert stage comes before the function. The shifts are run with both values of the incoming bit and on results whose end bits differ, and one case shifts a non-zero sum to zero to show that the flags follow the shifted value. A pair of slices is chained for a 16-bit add and a 16-bit shift.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;
  typedef enum logic [2:0] {
    FN_ADD  = 3'd0,
    FN_SUB  = 3'd1,
    FN_AND  = 3'd2,
    FN_OR   = 3'd3,
    FN_XOR  = 3'd4,
    FN_NAND = 3'd5,
    FN_NOR  = 3'd6,
    FN_XNOR = 3'd7
  } alu_fn_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'b00,
    SH_LEFT  = 2'b01,
    SH_RIGHT = 2'b10,
    SH_HOLD  = 2'b11
  } alu_sh_e;

  function automatic logic is_arith(input alu_fn_e fn);
    return (fn == FN_ADD) || (fn == FN_SUB);
  endfunction
endpackage

// File: rtl/alu_bit_cell.sv
module alu_bit_cell
  import alu_slice_pkg::*;
(
  input  logic    a_i,
  input  logic    b_i,
  input  logic    c_i,
  input  alu_fn_e fn_i,
  output logic    r_o,
  output logic    c_o
);
  logic and_b, or_b, xor_b;

  assign and_b = a_i & b_i;
  assign or_b  = a_i | b_i;
  assign xor_b = a_i ^ b_i;
  assign c_o   = and_b | (c_i & xor_b);

  always_comb begin
    unique case (fn_i)
      FN_ADD, FN_SUB: r_o = xor_b ^ c_i;
      FN_AND:         r_o = and_b;
      FN_OR:          r_o = or_b;
      FN_XOR:         r_o = xor_b;
      FN_NAND:        r_o = ~and_b;
      FN_NOR:         r_o = ~or_b;
      default:        r_o = ~xor_b;
    endcase
  end
endmodule

// File: rtl/alu_shift_stage.sv
module alu_shift_stage
  import alu_slice_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] d_i,
  input  alu_sh_e      sh_i,
  input  logic         sin_l_i,
  input  logic         sin_r_i,
  output logic [W-1:0] q_o,
  output logic         sout_o
);
  always_comb begin
    unique case (sh_i)
      SH_LEFT: begin
        q_o    = {d_i[W-2:0], sin_r_i};
        sout_o = d_i[W-1];
      end
      SH_RIGHT: begin
        q_o    = {sin_l_i, d_i[W-1:1]};
        sout_o = d_i[0];
      end
      default: begin
        q_o    = d_i;
        sout_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_slice_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic [2:0]   func_i,
  input  logic         binv_i,
  input  logic [1:0]   shift_i,
  input  logic         sin_l_i,
  input  logic         sin_r_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic         sout_o,
  output logic         sign_o,
  output logic         zero_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  alu_fn_e      fn;
  logic [W-1:0] b_eff;
  logic [W:0]   carry;
  logic [W-1:0] raw;
  logic         arith;

  assign fn    = alu_fn_e'(func_i);
  assign arith = is_arith(fn);
  // subtract adds one more complement on top of the binv stage
  assign b_eff = b_i ^ {W{binv_i ^ (fn == FN_SUB)}};
  assign carry[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_cell
    alu_bit_cell u_cell (
      .a_i  (a_i[i]),
      .b_i  (b_eff[i]),
      .c_i  (carry[i]),
      .fn_i (fn),
      .r_o  (raw[i]),
      .c_o  (carry[i+1])
    );
  end

  alu_shift_stage #(.W(W)) u_shift (
    .d_i     (raw),
    .sh_i    (alu_sh_e'(shift_i)),
    .sin_l_i (sin_l_i),
    .sin_r_i (sin_r_i),
    .q_o     (res_o),
    .sout_o  (sout_o)
  );

  assign cout_o = arith & carry[W];
  assign ovf_o  = arith & (carry[W] ^ carry[MSB]);
  assign sign_o = res_o[MSB];
  assign zero_o = ~|res_o;
endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] res_o,
  input logic [2:0]   func_i,
  input logic [1:0]   shift_i,
  input logic         sin_l_i,
  input logic         sin_r_i,
  input logic         cout_o,
  input logic         sout_o,
  input logic         sign_o,
  input logic         zero_o,
  input logic         ovf_o
);
  always_comb begin
    // R10
    sign_tracks_chk: assert (sign_o == res_o[W-1]) else $error("sign flag mismatch");
    // R10
    zero_tracks_chk: assert (zero_o == (res_o == '0)) else $error("zero flag mismatch");
    // R5
    logic_no_carry_chk: assert (func_i < 3'd2 || (!cout_o && !ovf_o)) else $error("carry/ovf on logic op");
    // R9
    no_shift_sout_chk: assert (shift_i == 2'b01 || shift_i == 2'b10 || !sout_o) else $error("sout without shift");
    // R7
    left_fill_chk: assert (shift_i != 2'b01 || res_o[0] == sin_r_i) else $error("left fill wrong");
    // R8
    right_fill_chk: assert (shift_i != 2'b10 || res_o[W-1] == sin_l_i) else $error("right fill wrong");
  end
endmodule

bind alu_slice alu_slice_chk #(.W(W)) u_chk (
  .res_o   (res_o),
  .func_i  (func_i),
  .shift_i (shift_i),
  .sin_l_i (sin_l_i),
  .sin_r_i (sin_r_i),
  .cout_o  (cout_o),
  .sout_o  (sout_o),
  .sign_o  (sign_o),
  .zero_o  (zero_o),
  .ovf_o   (ovf_o)
);

// File: tb/alu_slice_test.sv
module alu_slice_test;
  typedef struct packed {
    logic [3:0] rq;
    logic [7:0] a;
    logic [7:0] b;
    logic       cin;
    logic [2:0] fn;
    logic       binv;
    logic [1:0] sh;
    logic       sl;
    logic       sr;
    logic [7:0] res;
    logic       co;
    logic       so;
    logic       ov;
  } vec_t;

  localparam int NV = 24;
  // rq, a, b, cin, fn, binv, sh, sl, sr, res, co, so, ov
  localparam vec_t VECS [NV] = '{
    '{4'd1,  8'h35, 8'h4A, 1'b0, 3'd0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h7F, 1'b0, 1'b0, 1'b0}, // R1
    '{4'd6,  8'h7F, 8'h01, 1'b0, 3'd0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0, 1'b1}, // R6
    '{4'd6,  8'hFF, 8'h01, 1'b0, 3'd0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0}, // R6
    '{4'd6,  8'h80, 8'h80, 1'b0, 3'd0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1}, // R6
    '{4'd2,  8'h50, 8'h20, 1'b1, 3'd1, 1'b0, 2'b00, 1'b0, 1'b0, 8'h30, 1'b1, 1'b0, 1'b0}, // R2
    '{4'd2,  8'h20, 8'h50, 1'b1, 3'd1, 1'b0, 2'b00, 1'b0, 1'b0, 8'hD0, 1'b0, 1'b0, 1'b0}, // R2
    '{4'd2,  8'h80, 8'h01, 1'b1, 3'd1, 1'b0, 2'b00, 1'b0, 1'b0, 8'h7F, 1'b1, 1'b0, 1'b1}, // R2
    '{4'd3,  8'hCC, 8'hAA, 1'b0, 3'd2, 1'b0, 2'b00, 1'b0, 1'b0, 8'h88, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd4,  8'hCC, 8'hAA, 1'b0, 3'd2, 1'b1, 2'b00, 1'b0, 1'b0, 8'h44, 1'b0, 1'b0, 1'b0}, // R4
    '{4'd3,  8'hC0, 8'h0A, 1'b0, 3'd3, 1'b0, 2'b00, 1'b0, 1'b0, 8'hCA, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd3,  8'hCC, 8'hAA, 1'b0, 3'd4, 1'b0, 2'b00, 1'b0, 1'b0, 8'h66, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd3,  8'hCC, 8'hAA, 1'b0, 3'd5, 1'b0, 2'b00, 1'b0, 1'b0, 8'h77, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd3,  8'hCC, 8'hAA, 1'b0, 3'd6, 1'b0, 2'b00, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd3,  8'hCC, 8'hAA, 1'b0, 3'd7, 1'b0, 2'b00, 1'b0, 1'b0, 8'h99, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd4,  8'hF0, 8'h0F, 1'b0, 3'd4, 1'b1, 2'b00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R4
    '{4'd4,  8'h10, 8'h01, 1'b1, 3'd0, 1'b1, 2'b00, 1'b0, 1'b0, 8'h0F, 1'b1, 1'b0, 1'b0}, // R4
    '{4'd4,  8'h10, 8'h01, 1'b0, 3'd1, 1'b1, 2'b00, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0}, // R4
    '{4'd7,  8'h81, 8'h00, 1'b0, 3'd3, 1'b0, 2'b01, 1'b0, 1'b1, 8'h03, 1'b0, 1'b1, 1'b0}, // R7
    '{4'd7,  8'hFF, 8'h40, 1'b0, 3'd2, 1'b0, 2'b01, 1'b1, 1'b0, 8'h80, 1'b0, 1'b0, 1'b0}, // R7
    '{4'd8,  8'h81, 8'h00, 1'b0, 3'd3, 1'b0, 2'b10, 1'b1, 1'b0, 8'hC0, 1'b0, 1'b1, 1'b0}, // R8
    '{4'd8,  8'h01, 8'h00, 1'b0, 3'd3, 1'b0, 2'b10, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0}, // R8
    '{4'd10, 8'h7F, 8'h01, 1'b0, 3'd0, 1'b0, 2'b01, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1}, // R10
    '{4'd9,  8'h81, 8'h00, 1'b0, 3'd3, 1'b0, 2'b11, 1'b1, 1'b1, 8'h81, 1'b0, 1'b0, 1'b0}, // R9
    '{4'd1,  8'hFF, 8'h00, 1'b1, 3'd0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0}  // R1
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] a, b, res;
  logic [2:0] fn;
  logic [1:0] sh;
  logic cin, binv, sl, sr, co, so, sg, zr, ov;

  alu_slice uut (
    .a_i(a), .b_i(b), .cin_i(cin), .func_i(fn), .binv_i(binv), .shift_i(sh),
    .sin_l_i(sl), .sin_r_i(sr), .res_o(res), .cout_o(co), .sout_o(so),
    .sign_o(sg), .zero_o(zr), .ovf_o(ov)
  );

  // second slice for cascade tests
  logic [7:0] a_hi, b_hi, res_hi;
  logic [2:0] fn_hi;
  logic [1:0] sh_hi;
  logic binv_hi, sl_hi, co_hi, so_hi, sg_hi, zr_hi, ov_hi;

  alu_slice uut_hi (
    .a_i(a_hi), .b_i(b_hi), .cin_i(co), .func_i(fn_hi), .binv_i(binv_hi), .shift_i(sh_hi),
    .sin_l_i(sl_hi), .sin_r_i(so), .res_o(res_hi), .cout_o(co_hi), .sout_o(so_hi),
    .sign_o(sg_hi), .zero_o(zr_hi), .ovf_o(ov_hi)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input string rq, input string what, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", rq, what, got, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    a = v.a; b = v.b; cin = v.cin; fn = v.fn; binv = v.binv; sh = v.sh; sl = v.sl; sr = v.sr;
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0; fn = 3'd0; binv = 1'b0; sh = 2'b00; sl = 1'b0; sr = 1'b0;
    a_hi = '0; b_hi = '0; fn_hi = 3'd0; binv_hi = 1'b0; sh_hi = 2'b00; sl_hi = 1'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // idle inputs: zero sum, zero flag set (R1, R10)
    check("R1", "idle res", {8'h00, res}, 16'h0000);
    check("R10", "idle zero", {15'd0, zr}, 16'd1);

    for (int i = 0; i < NV; i++) begin
      string tag;
      @(posedge clk);
      drive(VECS[i]);
      @(negedge clk);
      tag = $sformatf("R%0d", VECS[i].rq);
      check(tag, $sformatf("v%0d res", i), {8'h00, res}, {8'h00, VECS[i].res});
      check(tag, $sformatf("v%0d cout", i), {15'd0, co}, {15'd0, VECS[i].co});
      check(tag, $sformatf("v%0d sout", i), {15'd0, so}, {15'd0, VECS[i].so});
      check(tag, $sformatf("v%0d ovf", i), {15'd0, ov}, {15'd0, VECS[i].ov});
      check("R10", $sformatf("v%0d sign", i), {15'd0, sg}, {15'd0, VECS[i].res[7]});
      check("R10", $sformatf("v%0d zero", i), {15'd0, zr}, {15'd0, (VECS[i].res == 8'h00)});
    end

    // R5: logic op with inputs that would carry and overflow as a sum
    @(posedge clk);
    a = 8'hC0; b = 8'hC0; cin = 1'b1; fn = 3'd3; binv = 1'b0; sh = 2'b00;
    @(negedge clk);
    check("R5", "or cout", {15'd0, co}, 16'd0);
    check("R5", "or ovf", {15'd0, ov}, 16'd0);

    // R11: 16-bit add 0x12FF + 0x0001 = 0x1300
    @(posedge clk);
    a = 8'hFF; b = 8'h01; cin = 1'b0; fn = 3'd0; binv = 1'b0; sh = 2'b00;
    a_hi = 8'h12; b_hi = 8'h00; fn_hi = 3'd0; binv_hi = 1'b0; sh_hi = 2'b00;
    @(negedge clk);
    check("R11", "16b add", {res_hi, res}, 16'h1300);
    check("R11", "16b add cout", {15'd0, co_hi}, 16'd0);

    // R11: 16-bit subtract 0x1000 - 0x0001 = 0x0FFF
    @(posedge clk);
    a = 8'h00; b = 8'h01; cin = 1'b1; fn = 3'd1;
    a_hi = 8'h10; b_hi = 8'h00; fn_hi = 3'd1;
    @(negedge clk);
    check("R11", "16b sub", {res_hi, res}, 16'h0FFF);

    // R11: 16-bit left shift of 0x4180 (OR with zero), fill 1 -> 0x8301, sout 0
    @(posedge clk);
    a = 8'h80; b = 8'h00; cin = 1'b0; fn = 3'd3; sh = 2'b01; sr = 1'b1;
    a_hi = 8'h41; b_hi = 8'h00; fn_hi = 3'd3; sh_hi = 2'b01;
    @(negedge clk);
    check("R11", "16b shl", {res_hi, res}, 16'h8301);
    check("R11", "16b shl sout", {15'd0, so_hi}, 16'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule